// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Entry Word Queue

The block turns an asynchronous serial line into parallel words. A baud tick input runs at sixteen times the bit rate. On each tick the receiver samples the line, which passes through a synchroniser first. It finds a start edge, confirms the start at its centre, and then takes every data bit at mid-bit, least significant bit first. An optional ninth bit follows the eight data bits. At the centre of the stop bit, the word moves into a two-entry queue together with its ninth bit and its framing status.

The consumer sees the head entry of the queue on the read outputs. A one-cycle pop strobe removes that entry, and the outputs then show the next one. A data-available flag stays high while the queue holds anything. An interrupt line equals that flag gated by an enable.

If a word completes while the queue is full, the block raises a sticky overrun flag and discards the word. Until the receive enable is dropped and raised again, no further word enters the queue.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset, data_avail, irq and overrun are 0.
- R2: With ninth_en = 0, a frame is one low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts 16 ticks. The frame appears as rd_data, with rd_bit9 = 0 and rd_ferr = 0.
- R3: With ninth_en = 1, a ninth data bit follows the eight data bits. It is reported on rd_bit9, next to the same rd_data.
- R4: A low level on the line starts a frame only if the line is still low at the 8th tick, counting the detecting tick as the first. A shorter low pulse stores nothing.
- R5: A stop bit sampled low still stores the word, and sets rd_ferr = 1 for that entry. The receiver then waits for the line to return high before it looks for a new start.
- R6: The queue holds two entries, in arrival order. Each entry shows its own rd_bit9 and rd_ferr while it is at the head.
- R7: If a stop bit is sampled while the queue holds two entries and no pop happens in that cycle, overrun sets and the word is discarded.
- R8: While overrun is 1, no completed word enters the queue, even after the queue has been drained.
- R9: overrun clears only while rx_en is 0. Entries already queued are kept, and reception resumes once rx_en is 1 again.
- R10: While rx_en is 0, line activity stores nothing.
- R11: irq is data_avail AND irq_en. data_avail drops when the last entry is popped.
- R12: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; a low level clears overrun |
| ninth_en | input | 1 | 1 selects nine data bits per frame |
| irq_en | input | 1 | Interrupt enable |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| rd_pop | input | 1 | Removes the head entry of the queue |
| rd_data | output | DATA_W | Data of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rd_ferr | output | 1 | Framing error of the head entry |
| data_avail | output | 1 | Queue is not empty |
| irq | output | 1 | data_avail gated by irq_en |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bound assertions check the rules that hold on every cycle:
- overrun stays set while rx_en is high and falls only after rx_en was low;
- nothing is pushed while overrun is set or rx_en is low;
- the queue never holds more than its depth, and overrun rises only from a full queue;
- a pop on an empty queue leaves it empty.

Only the bench scenarios can show the rest:
- that words are recovered from real frames bit by bit;
- that the ninth bit and the framing flag stay with their own word;
- that short start glitches are rejected;
- that the overrun sequence keeps the first two words and drops the later ones.

// File: rtl/srq_pkg.sv
// Package: shared state encoding for the serial receiver queue.
// Assumes: nothing beyond IEEE 1800-2017.
package srq_pkg;
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_BREAK = 3'd4
    } rx_state_t;
endpackage

// File: rtl/srq_line_sync.sv
// Module: srq_line_sync
// Brings the asynchronous serial line into the clock domain with a flop chain.
// Assumes: the line idles high, so every stage resets to 1.
module srq_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
    end

    assign line_out = chain[STAGES-1];
endmodule

// File: rtl/srq_framer.sv
// Module: srq_framer
// Recovers one frame per start bit from a 16x oversampled line.
// It checks the start at its centre, takes each data bit at mid-bit (LSB first),
// and samples the stop bit. It issues a one-cycle done pulse with the word,
// the ninth bit and the framing status.
// Assumes: tick is a one-cycle strobe; the line is already synchronised.
module srq_framer
    import srq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ninth_en,
    input  logic              tick,
    input  logic              line,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output logic              bit9,
    output logic              ferr
);
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam int unsigned HALF  = OVS / 2;
    localparam int unsigned BIT_W = $clog2(DATA_W + 2);

    rx_state_t          st;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bitn;
    logic [DATA_W:0]    shreg;
    logic               mode9;
    logic [BIT_W-1:0]   last_bit;

    // Index of the final data bit for the mode latched at the start.
    always_comb last_bit = mode9 ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);

    // Frame sequencing, bit sampling and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            mode9 <= 1'b0;
            done  <= 1'b0;
            word  <= '0;
            bit9  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                st <= RX_IDLE;
            end else if (tick) begin
                case (st)
                    RX_IDLE: begin
                        if (!line) begin
                            st    <= RX_START;
                            cnt   <= CNT_W'(1);
                            mode9 <= ninth_en;
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_W'(HALF - 1)) begin
                            if (line) begin
                                st <= RX_IDLE;
                            end else begin
                                st   <= RX_DATA;
                                cnt  <= '0;
                                bitn <= '0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[DATA_W:1]};
                            bitn  <= bitn + 1'b1;
                            if (bitn == last_bit) st <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CNT_W'(OVS - 1)) begin
                            cnt  <= '0;
                            done <= 1'b1;
                            ferr <= ~line;
                            st   <= line ? RX_IDLE : RX_BREAK;
                            if (mode9) begin
                                word <= shreg[DATA_W-1:0];
                                bit9 <= shreg[DATA_W];
                            end else begin
                                word <= shreg[DATA_W:1];
                                bit9 <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_BREAK: begin
                        if (line) st <= RX_IDLE;
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srq_queue.sv
// Module: srq_queue
// Small circular queue of status-tagged words. The head entry is visible
// combinationally. A pop on an empty queue is ignored.
// Assumes: the caller never pushes into a full queue unless it pops in the same cycle.
module srq_queue #(
    parameter int unsigned W     = 10,
    parameter int unsigned DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    output logic                       full,
    output logic                       empty
);
    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned FILL_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             pop_ok;

    assign empty  = (fill == '0);
    assign full   = (fill == FILL_W'(DEPTH));
    assign pop_ok = pop && !empty;
    assign dout   = mem[rd_ptr];

    // Next position of a pointer with explicit wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push)   wr_ptr <= bump(wr_ptr);
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            if (push && !pop_ok)      fill <= fill + 1'b1;
            else if (!push && pop_ok) fill <= fill - 1'b1;
        end
    end
endmodule

// File: rtl/srq_admit.sv
// Module: srq_admit
// Decides whether a completed frame enters the queue, and keeps the sticky
// overrun flag. Overrun clears whenever the receive enable is low.
// Assumes: done is a one-cycle pulse per completed frame.
module srq_admit (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic done,
    input  logic full,
    input  logic pop,
    output logic push,
    output logic overrun
);
    logic room;

    // A full queue still has room if its head leaves in the same cycle.
    assign room = !full || pop;
    assign push = done && rx_en && !overrun && room;

    // Sticky overrun: set on a frame with no room, cleared by disabling reception.
    always_ff @(posedge clk) begin
        if (!rst_n)                               overrun <= 1'b0;
        else if (!rx_en)                          overrun <= 1'b0;
        else if (done && !overrun && !room)       overrun <= 1'b1;
    end
endmodule

// File: rtl/serial_rx_queue.sv
// Module: serial_rx_queue (top)
// Oversampled serial receiver feeding a queue of entries tagged with the
// ninth bit and the framing status, with a gated interrupt and sticky overrun.
// Assumes: baud_tick pulses at OVS times the bit rate; the line idles high.
module serial_rx_queue #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned OVS         = 16,
    parameter int unsigned DEPTH       = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              ninth_en,
    input  logic              irq_en,
    input  logic              baud_tick,
    input  logic              rx_line,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rd_ferr,
    output logic              data_avail,
    output logic              irq,
    output logic              overrun
);
    localparam int unsigned ENT_W  = DATA_W + 2;
    localparam int unsigned FILL_W = $clog2(DEPTH + 1);

    logic              line_s;
    logic              f_done;
    logic [DATA_W-1:0] f_word;
    logic              f_bit9;
    logic              f_ferr;
    logic              push_w;
    logic              q_full;
    logic              q_empty;
    logic [FILL_W-1:0] q_fill;
    logic [ENT_W-1:0]  q_head;

    srq_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (rx_line),
        .line_out (line_s)
    );

    srq_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (rx_en),
        .ninth_en (ninth_en),
        .tick     (baud_tick),
        .line     (line_s),
        .done     (f_done),
        .word     (f_word),
        .bit9     (f_bit9),
        .ferr     (f_ferr)
    );

    srq_admit u_admit (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .done    (f_done),
        .full    (q_full),
        .pop     (rd_pop),
        .push    (push_w),
        .overrun (overrun)
    );

    srq_queue #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_w),
        .din   ({f_ferr, f_bit9, f_word}),
        .pop   (rd_pop),
        .dout  (q_head),
        .fill  (q_fill),
        .full  (q_full),
        .empty (q_empty)
    );

    assign rd_data    = q_head[DATA_W-1:0];
    assign rd_bit9    = q_head[DATA_W];
    assign rd_ferr    = q_head[DATA_W+1];
    assign data_avail = !q_empty;
    assign irq        = data_avail && irq_en;
endmodule

// File: rtl/srq_checker.sv
// Module: srq_checker
// Cycle-level rules for serial_rx_queue, attached by bind.
// Assumes: fill and push are the queue occupancy and the admission strobe.
module srq_checker #(
    parameter int unsigned DEPTH  = 2,
    parameter int unsigned FILL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rd_pop,
    input logic              data_avail,
    input logic              overrun,
    input logic              push,
    input logic [FILL_W-1:0] fill
);
    assert_ovr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en) |=> overrun);

    assert_ovr_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !push);

    assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> !$past(rx_en));

    assert_ovr_from_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(fill) == FILL_W'(DEPTH)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));

    assert_off_no_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !push);

    assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && rd_pop && !push) |=> (fill == '0));

    assert_last_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FILL_W'(1) && rd_pop && !push) |=> !data_avail);
endmodule

bind serial_rx_queue srq_checker #(
    .DEPTH  (DEPTH),
    .FILL_W ($clog2(DEPTH + 1))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rd_pop     (rd_pop),
    .data_avail (data_avail),
    .overrun    (overrun),
    .push       (push_w),
    .fill       (u_fifo.fill)
);

// File: tb/sim_serial_rx_queue.sv
module sim_serial_rx_queue;
    localparam int TICK_DIV = 3;
    localparam int OVS      = 16;
    localparam int NVEC     = 6;
    // {ninth_en, payload[8:0], stop level, exp data[7:0], exp bit9, exp ferr}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 9'h0A5, 1'b1, 8'hA5, 1'b0, 1'b0},
        {1'b0, 9'h13C, 1'b1, 8'h3C, 1'b0, 1'b0},
        {1'b1, 9'h15A, 1'b1, 8'h5A, 1'b1, 1'b0},
        {1'b1, 9'h0FF, 1'b1, 8'hFF, 1'b0, 1'b0},
        {1'b0, 9'h000, 1'b0, 8'h00, 1'b0, 1'b1},
        {1'b1, 9'h181, 1'b0, 8'h81, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0;
    logic ninth_en = 1'b0;
    logic irq_en = 1'b0;
    logic baud_tick = 1'b0;
    logic rx_line = 1'b1;
    logic rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic rd_bit9, rd_ferr, data_avail, irq, overrun;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int tdiv = 0;

    always #10 clk = ~clk;

    serial_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ninth_en(ninth_en),
        .irq_en(irq_en), .baud_tick(baud_tick), .rx_line(rx_line),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9),
        .rd_ferr(rd_ferr), .data_avail(data_avail), .irq(irq),
        .overrun(overrun)
    );

    // Free-running oversampling tick, one clock in TICK_DIV.
    always @(negedge clk) begin
        tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == 0);
    end

    task automatic check(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic hold_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    task automatic send(input logic nine, input logic [8:0] pay, input logic stop);
        ninth_en = nine;
        rx_line = 1'b0;
        hold_ticks(OVS);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rx_line = pay[i];
            hold_ticks(OVS);
        end
        rx_line = stop;
        hold_ticks(OVS);
        rx_line = 1'b1;
        hold_ticks(2 * OVS);
    endtask

    task automatic pop1();
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(data_avail, 0, "R1 data_avail");
        check(overrun, 0, "R1 overrun");
        check(irq, 0, "R1 irq");
        rst_n = 1'b1;
        rx_en = 1'b1;
        hold_ticks(4);

        // R2 R3 R5: table of frames
        foreach (VEC[k]) begin
            send(VEC[k][20], VEC[k][19:11], VEC[k][10]);
            check(data_avail, 1, $sformatf("R2 vec%0d avail", k));
            check(rd_data, VEC[k][9:2], $sformatf("R2 vec%0d data", k));
            check(rd_bit9, VEC[k][1], $sformatf("R3 vec%0d bit9", k));
            check(rd_ferr, VEC[k][0], $sformatf("R5 vec%0d ferr", k));
            pop1();
            check(data_avail, 0, $sformatf("R11 vec%0d drained", k));
        end

        // R4: glitch shorter than the start centre is rejected
        ninth_en = 1'b0;
        rx_line = 1'b0;
        hold_ticks(4);
        rx_line = 1'b1;
        hold_ticks(3 * OVS);
        check(data_avail, 0, "R4 glitch stored nothing");

        // R12: pop on empty queue, then a frame arrives normally
        pop1();
        check(data_avail, 0, "R12 empty pop");
        send(1'b0, 9'h066, 1'b1);
        check(rd_data, 8'h66, "R12 queue intact after empty pop");

        // R11: interrupt gating
        check(irq, 0, "R11 irq masked");
        irq_en = 1'b1;
        @(negedge clk);
        check(irq, 1, "R11 irq enabled");
        pop1();
        check(irq, 0, "R11 irq after drain");

        // R6 R7: three frames, the third overruns
        send(1'b1, 9'h111, 1'b1);
        send(1'b0, 9'h022, 1'b0);
        check(overrun, 0, "R7 no overrun at two entries");
        send(1'b0, 9'h033, 1'b1);
        check(overrun, 1, "R7 overrun set");
        check(rd_data, 8'h11, "R6 first entry data");
        check(rd_bit9, 1, "R6 first entry bit9");
        check(rd_ferr, 0, "R6 first entry ferr");
        pop1();
        check(rd_data, 8'h22, "R6 second entry data");
        check(rd_bit9, 0, "R6 second entry bit9");
        check(rd_ferr, 1, "R6 second entry ferr");
        pop1();
        check(data_avail, 0, "R7 third word discarded");

        // R8: blocked while overrun
        send(1'b0, 9'h044, 1'b1);
        check(data_avail, 0, "R8 blocked after drain");
        check(overrun, 1, "R8 overrun sticky");

        // R9: clear by toggling the enable, entries retained
        rx_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(overrun, 0, "R9 overrun cleared");

        // R10: reception disabled ignores the line
        send(1'b0, 9'h055, 1'b1);
        check(data_avail, 0, "R10 disabled stores nothing");

        rx_en = 1'b1;
        hold_ticks(4);
        send(1'b0, 9'h077, 1'b1);
        check(data_avail, 1, "R9 resumed avail");
        check(rd_data, 8'h77, "R9 resumed data");
        check(overrun, 0, "R9 overrun stays clear");

        finish_run();
    end
endmodule